// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter

This block turns bytes written over a byte-wide register port into asynchronous serial frames on a single output line that idles high. Software sets the bit period through a 16-bit divisor and a double-speed bit, chooses the character length (5 to 9 data bits), the parity and the number of stop bits, and then writes characters to a data register. A one-deep holding buffer sits in front of the shift register, so the next character can be queued while the current one is still going out.

Two status flags report progress. The buffer-empty flag shows that a new character may be written. The transmission-done flag shows that the line has gone quiet with nothing queued. Each flag drives a level interrupt request, gated by its own enable bit and by a global enable input. An acknowledge input clears the matching flag. The interrupt controller is outside the block.

Register map (3-bit address): 0 status, 1 control, 2 format, 3 divisor low byte, 4 divisor high byte, 5 data. Status bits: 6 = done, 5 = buffer empty, 1 = double speed; all other status bits read 0. Control bits: 6 = done interrupt enable, 5 = empty interrupt enable, 4 and 7 = stored only, 3 = transmitter enable, 2 = size code bit 2, 1 = reads 0, 0 = ninth data bit. Format bits: 5:4 = parity mode, 3 = two stop bits, 2:1 = size code bits 1:0, 7:6 and 0 = stored only.

Top module: `uart_tx_core`

## Requirements
- R1: A frame is one low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits (high). While no frame is being sent, `txd` is high.
- R2: Every bit lasts M × (DIV + 1) clock cycles. DIV = {divisor high byte, divisor low byte}. M = 8 when status bit 1 is set and 16 when it is clear. The start bit goes low on the second clock edge after the data write.
- R3: The 3-bit size code {control bit 2, format bits 2:1} selects the number of data bits: 0→5, 1→6, 2→7, 3→8, and 4 to 7→9. The ninth data bit is taken from control bit 0 when the character is written.
- R4: Format bits 5:4 select the parity: 2 = even, 3 = odd, 0 or 1 = no parity bit. Format bit 3 = 1 sends two stop bits, otherwise one.
- R5: A data write while enabled clears the empty flag (status bit 5) on that edge. The flag is set again on the edge where the character enters the shifter. A character written during a frame is sent immediately after that frame's last stop bit, with no idle gap.
- R6: The done flag (status bit 6) is set when the last stop bit ends and no character follows it. Writing 1 to status bit 6 clears the done flag. Writes to status bit 5 have no effect.
- R7: When control bit 3 (transmitter enable) changes from 0 to 1, the empty flag is set.
- R8: While control bit 3 is 0, data writes have no effect. Clearing control bit 3 during a frame lets that frame finish unchanged.
- R9: `irq_empty` = empty flag AND control bit 5 AND `gie`. `irq_done` = done flag AND control bit 6 AND `gie`. `ack_empty` and `ack_done` each clear their flag. A flag set in the same cycle as its acknowledge wins.
- R10: After reset: status reads 0x20, control 0x00, format 0x06, divisor 0, and the outputs are idle. Every register reads back what was written, except control bit 1, which reads 0. The data address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the register selected by `bus_addr` (combinational) |
| gie | input | 1 | Global interrupt enable |
| ack_empty | input | 1 | Acknowledge; clears the empty flag |
| ack_done | input | 1 | Acknowledge; clears the done flag |
| txd | output | 1 | Serial output line |
| irq_empty | output | 1 | Buffer-empty interrupt request (level) |
| irq_done | output | 1 | Transmission-done interrupt request (level) |

## Verification
The assertions check the following on every cycle:
- the line is high whenever the shifter is idle;
- every frame opens with a low start bit;
- the line holds between bit ticks, and a started frame runs on whatever the enable bit does;
- the empty flag follows data writes, hand-overs and enable rising edges;
- the done flag follows frame ends and acknowledges;
- data writes while disabled leave the buffer untouched;
- the requests stay low while `gie` is low.

Other behaviour can only be shown by the bench's scenarios, which compare the line in every cycle against frames computed from the requirements:
- the exact bit period for each divisor and prescale;
- the data, parity and stop content for each size code and parity mode;
- the gap-free back-to-back frame;
- the register readback.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int BUS_W    = 8;
    localparam int ADDR_W   = 3;
    localparam int MAX_DATA = 9;
    localparam int FRAME_W  = 1 + MAX_DATA + 1 + 2;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    // register addresses
    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_FMT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIVL = 3'd3;
    localparam logic [ADDR_W-1:0] A_DIVH = 3'd4;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd5;

    // status bit positions
    localparam int ST_DONE  = 6;
    localparam int ST_EMPTY = 5;
    localparam int ST_DBL   = 1;

    // control bit positions
    localparam int CT_IE_DONE  = 6;
    localparam int CT_IE_EMPTY = 5;
    localparam int CT_EN       = 3;
    localparam int CT_SZ2      = 2;
    localparam int CT_RX8      = 1;
    localparam int CT_TX8      = 0;

    // format bit positions
    localparam int FM_PAR_LO = 4;
    localparam int FM_STOP2  = 3;
    localparam int FM_SZ_LO  = 1;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_RSVD = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } parity_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   nbits;
    } frame_t;

    // Build the whole frame, LSB = first bit on the line; unused upper bits are 1 (stop / idle)
    function automatic frame_t build_frame(input logic [MAX_DATA-1:0] d,
                                           input logic [2:0]          sz,
                                           input logic [1:0]          par,
                                           input logic                stop2);
        frame_t     f;
        logic [LEN_W-1:0] dbits;
        logic       ones;
        logic       has_par;
        logic       pbit;
        f.bits    = '1;
        f.bits[0] = 1'b0;
        ones      = 1'b0;
        case (sz)
            3'd0:    dbits = LEN_W'(5);
            3'd1:    dbits = LEN_W'(6);
            3'd2:    dbits = LEN_W'(7);
            3'd3:    dbits = LEN_W'(8);
            default: dbits = LEN_W'(9);
        endcase
        for (int i = 0; i < MAX_DATA; i++) begin
            if (LEN_W'(i) < dbits) begin
                f.bits[1+i] = d[i];
                ones        = ones ^ d[i];
            end
        end
        has_par = (parity_e'(par) == PAR_EVEN) || (parity_e'(par) == PAR_ODD);
        pbit    = (parity_e'(par) == PAR_ODD) ? ~ones : ones;
        for (int p = 5; p <= MAX_DATA; p++) begin
            if (has_par && dbits == LEN_W'(p)) f.bits[1+p] = pbit;
        end
        f.nbits = LEN_W'(2) + dbits + LEN_W'(has_par) + LEN_W'(stop2);
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             dbl,
    input  logic             busy,
    input  logic             restart,
    output logic             tick
);

    localparam int CNT_W = DIV_W + 5;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_t;

    baud_t            b_d, b_q;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] span_m1;

    always_comb begin
        base    = CNT_W'(div) + CNT_W'(1);
        span_m1 = (dbl ? (base << 3) : (base << 4)) - CNT_W'(1);
        tick    = busy && (b_q.cnt >= span_m1);
        b_d     = b_q;
        if (restart || !busy || tick) begin
            b_d.cnt = '0;
        end else begin
            b_d.cnt = b_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

endmodule

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic                ack_empty,
    input  logic                ack_done,
    input  logic                load,
    input  logic                frame_done,
    output logic                tx_en,
    output logic                ie_empty,
    output logic                ie_done,
    output logic                dbl,
    output logic [2:0]          size_code,
    output logic [1:0]          par_mode,
    output logic                stop2,
    output logic [DIV_W-1:0]    div,
    output logic                empty_flag,
    output logic                done_flag,
    output logic                push,
    output logic [MAX_DATA-1:0] push_data
);

    localparam logic [BUS_W-1:0] CTL_MASK  = ~(BUS_W'(1) << CT_RX8);
    localparam logic [BUS_W-1:0] FMT_RESET = 8'h06;

    typedef struct packed {
        logic             dbl;
        logic [BUS_W-1:0] ctl;
        logic [BUS_W-1:0] fmt;
        logic [DIV_W-1:0] div;
        logic             empty;
        logic             done;
    } regs_t;

    localparam regs_t RESET_VAL = '{dbl: 1'b0, ctl: '0, fmt: FMT_RESET,
                                    div: '0, empty: 1'b1, done: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        push = 1'b0;

        // acknowledges clear first so that set events below win
        if (ack_empty) r_d.empty = 1'b0;
        if (ack_done)  r_d.done  = 1'b0;

        if (bus_wr) begin
            case (bus_addr)
                A_STAT: begin
                    r_d.dbl = bus_wdata[ST_DBL];
                    if (bus_wdata[ST_DONE]) r_d.done = 1'b0;
                end
                A_CTRL: begin
                    r_d.ctl = bus_wdata & CTL_MASK;
                    if (!r_q.ctl[CT_EN] && bus_wdata[CT_EN]) r_d.empty = 1'b1;
                end
                A_FMT:  r_d.fmt = bus_wdata;
                A_DIVL: r_d.div[7:0] = bus_wdata;
                A_DIVH: r_d.div[DIV_W-1:8] = bus_wdata[DIV_W-9:0];
                default: ;
            endcase
        end

        if (load)       r_d.empty = 1'b1;
        if (frame_done) r_d.done  = 1'b1;

        // a fresh character always leaves the buffer full
        if (bus_wr && bus_addr == A_DATA && r_q.ctl[CT_EN]) begin
            push      = 1'b1;
            r_d.empty = 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            A_STAT:  bus_rdata = {1'b0, r_q.done, r_q.empty, 3'b000, r_q.dbl, 1'b0};
            A_CTRL:  bus_rdata = r_q.ctl;
            A_FMT:   bus_rdata = r_q.fmt;
            A_DIVL:  bus_rdata = r_q.div[7:0];
            A_DIVH:  bus_rdata = BUS_W'(r_q.div[DIV_W-1:8]);
            default: bus_rdata = '0;
        endcase
    end

    assign push_data  = {r_q.ctl[CT_TX8], bus_wdata};
    assign tx_en      = r_q.ctl[CT_EN];
    assign ie_empty   = r_q.ctl[CT_IE_EMPTY];
    assign ie_done    = r_q.ctl[CT_IE_DONE];
    assign dbl        = r_q.dbl;
    assign size_code  = {r_q.ctl[CT_SZ2], r_q.fmt[FM_SZ_LO+1:FM_SZ_LO]};
    assign par_mode   = r_q.fmt[FM_PAR_LO+1:FM_PAR_LO];
    assign stop2      = r_q.fmt[FM_STOP2];
    assign div        = r_q.div;
    assign empty_flag = r_q.empty;
    assign done_flag  = r_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                push,
    input  logic [MAX_DATA-1:0] push_data,
    input  logic [2:0]          size_code,
    input  logic [1:0]          par_mode,
    input  logic                stop2,
    input  logic                tick,
    output logic                txd,
    output logic                busy,
    output logic                load,
    output logic                frame_done,
    output logic                hold_valid
);

    typedef struct packed {
        logic                busy;
        logic [FRAME_W-1:0]  sr;
        logic [LEN_W-1:0]    left;
        logic                hold_v;
        logic [MAX_DATA-1:0] hold;
    } shift_t;

    shift_t s_d, s_q;
    frame_t fr;
    logic   start_ok;

    always_comb begin
        fr         = build_frame(s_q.hold, size_code, par_mode, stop2);
        start_ok   = tx_en && s_q.hold_v;
        s_d        = s_q;
        load       = 1'b0;
        frame_done = 1'b0;

        if (s_q.busy) begin
            if (tick) begin
                if (s_q.left == LEN_W'(1)) begin
                    if (start_ok) begin
                        load = 1'b1;
                    end else begin
                        s_d.busy   = 1'b0;
                        frame_done = 1'b1;
                    end
                end else begin
                    s_d.sr   = {1'b1, s_q.sr[FRAME_W-1:1]};
                    s_d.left = s_q.left - LEN_W'(1);
                end
            end
        end else if (start_ok) begin
            load = 1'b1;
        end

        if (load) begin
            s_d.busy   = 1'b1;
            s_d.sr     = fr.bits;
            s_d.left   = fr.nbits;
            s_d.hold_v = 1'b0;
        end

        if (push) begin
            s_d.hold_v = 1'b1;
            s_d.hold   = push_data;
        end
    end

    assign txd        = s_q.busy ? s_q.sr[0] : 1'b1;
    assign busy       = s_q.busy;
    assign hold_valid = s_q.hold_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              gie,
    input  logic              ack_empty,
    input  logic              ack_done,
    output logic              txd,
    output logic              irq_empty,
    output logic              irq_done
);

    logic                tx_en, ie_empty, ie_done, dbl, stop2;
    logic [2:0]          size_code;
    logic [1:0]          par_mode;
    logic [DIV_W-1:0]    div;
    logic                empty_flag, done_flag;
    logic                push;
    logic [MAX_DATA-1:0] push_data;
    logic                busy, tick, load, frame_done, hold_valid;

    uart_tx_regs #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ack_empty  (ack_empty),
        .ack_done   (ack_done),
        .load       (load),
        .frame_done (frame_done),
        .tx_en      (tx_en),
        .ie_empty   (ie_empty),
        .ie_done    (ie_done),
        .dbl        (dbl),
        .size_code  (size_code),
        .par_mode   (par_mode),
        .stop2      (stop2),
        .div        (div),
        .empty_flag (empty_flag),
        .done_flag  (done_flag),
        .push       (push),
        .push_data  (push_data)
    );

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .div     (div),
        .dbl     (dbl),
        .busy    (busy),
        .restart (load),
        .tick    (tick)
    );

    uart_tx_shift u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .push       (push),
        .push_data  (push_data),
        .size_code  (size_code),
        .par_mode   (par_mode),
        .stop2      (stop2),
        .tick       (tick),
        .txd        (txd),
        .busy       (busy),
        .load       (load),
        .frame_done (frame_done),
        .hold_valid (hold_valid)
    );

    assign irq_empty = gie & ie_empty & empty_flag;
    assign irq_done  = gie & ie_done & done_flag;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk
    import uart_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              gie,
    input logic              ack_done,
    input logic              txd,
    input logic              irq_empty,
    input logic              irq_done,
    input logic              tx_en,
    input logic              empty_flag,
    input logic              done_flag,
    input logic              busy,
    input logic              tick,
    input logic              load,
    input logic              frame_done,
    input logic              hold_valid
);

    logic data_wr;
    assign data_wr = bus_wr && (bus_addr == A_DATA);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    assert_bit_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(txd));

    assert_empty_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_en) |=> !empty_flag);

    assert_empty_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !data_wr) |=> empty_flag);

    assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> done_flag);

    assert_enable_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> empty_flag);

    assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !tx_en) |=> $stable(hold_valid));

    assert_frame_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);

    assert_ack_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !frame_done) |=> !done_flag);

    assert_gie_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq_empty && !irq_done));

endmodule

bind uart_tx_core uart_tx_core_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .gie        (gie),
    .ack_done   (ack_done),
    .txd        (txd),
    .irq_empty  (irq_empty),
    .irq_done   (irq_done),
    .tx_en      (tx_en),
    .empty_flag (empty_flag),
    .done_flag  (done_flag),
    .busy       (busy),
    .tick       (tick),
    .load       (load),
    .frame_done (frame_done),
    .hold_valid (hold_valid)
);

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       gie, ack_empty, ack_done;
    logic       txd, irq_empty, irq_done;

    always #4 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gie       (gie),
        .ack_empty (ack_empty),
        .ack_done  (ack_done),
        .txd       (txd),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // vector: [31:29] size code, [28:27] parity, [26] two stops, [25] double speed,
    //         [24] ninth bit, [23:8] divisor, [7:0] data
    localparam logic [31:0] VEC [8] = '{
        32'h620000A5, 32'h12000113, 32'h3C00002C, 32'h46000255,
        32'hF300000F, 32'h9E0000F0, 32'h68000181, 32'h7E000300
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_ack(input bit which_done);
        @(negedge clk);
        if (which_done) ack_done = 1'b1; else ack_empty = 1'b1;
        @(negedge clk);
        ack_done  = 1'b0;
        ack_empty = 1'b0;
    endtask

    // expected frame from the requirements, first line bit at index 0
    function automatic void exp_frame(input logic [8:0] d, input logic [2:0] sz,
                                      input logic [1:0] par, input logic st2,
                                      output logic [31:0] f, output int n);
        int   db;
        logic x;
        db   = (sz < 3'd4) ? 5 + int'(sz) : 9;
        f    = '1;
        f[0] = 1'b0;
        x    = 1'b0;
        for (int i = 0; i < db; i++) begin
            f[1+i] = d[i];
            x      = x ^ d[i];
        end
        n = 1 + db;
        if (par == 2'd2) begin f[n] = x;  n++; end
        else if (par == 2'd3) begin f[n] = ~x; n++; end
        n = n + (st2 ? 2 : 1);
    endfunction

    // waits for the start bit, then compares the line at every cycle of the frame
    task automatic capture(input logic [31:0] bits, input int n, input int p, input string req);
        int   waited = 0;
        int   bad    = -1;
        logic got    = 1'b0;
        do begin
            @(negedge clk);
            waited++;
        end while (txd !== 1'b0 && waited < 200);
        chk(waited == 1, req, "start bit delay", waited, 1);
        for (int c = 0; c < n * p; c++) begin
            if (c > 0) @(negedge clk);
            if (txd !== bits[c / p] && bad < 0) begin
                bad = c;
                got = txd;
            end
        end
        chk(bad < 0, req, "line bit", int'(got), (bad < 0) ? 0 : int'(bits[bad / p]));
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rv;
        logic [31:0] f, f2;
        int          n, n2, p;
        bit          all_high;

        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        gie = 1'b0; ack_empty = 1'b0; ack_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(3'd0, rv); chk(rv == 8'h20, "R10", "status after reset", rv, 8'h20);
        rd(3'd1, rv); chk(rv == 8'h00, "R10", "control after reset", rv, 8'h00);
        rd(3'd2, rv); chk(rv == 8'h06, "R10", "format after reset", rv, 8'h06);
        rd(3'd3, rv); chk(rv == 8'h00, "R10", "divisor low after reset", rv, 8'h00);
        chk(txd === 1'b1 && irq_empty === 1'b0 && irq_done === 1'b0, "R10", "outputs after reset",
            {txd, irq_empty, irq_done}, 3'b100);

        // R8 data write while disabled has no effect
        wr(3'd5, 8'h3C);
        rd(3'd0, rv); chk(rv == 8'h20, "R8", "status after disabled write", rv, 8'h20);
        all_high = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) all_high = 0;
        end
        chk(all_high, "R8", "line while disabled", 0, 1);

        // R7 enable rise sets empty
        pulse_ack(1'b0);
        rd(3'd0, rv); chk(rv == 8'h00, "R9", "empty after ack", rv, 8'h00);
        wr(3'd1, 8'h08);
        rd(3'd0, rv); chk(rv == 8'h20, "R7", "empty after enable rise", rv, 8'h20);

        // R10 readback
        wr(3'd3, 8'h5A); wr(3'd4, 8'hC3); wr(3'd1, 8'h0B);
        rd(3'd3, rv); chk(rv == 8'h5A, "R10", "divisor low readback", rv, 8'h5A);
        rd(3'd4, rv); chk(rv == 8'hC3, "R10", "divisor high readback", rv, 8'hC3);
        rd(3'd1, rv); chk(rv == 8'h09, "R10", "control bit 1 reads 0", rv, 8'h09);
        rd(3'd5, rv); chk(rv == 8'h00, "R10", "data address reads 0", rv, 8'h00);

        // table of frame formats: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < 8; v++) begin
            logic [31:0] t;
            t = VEC[v];
            wr(3'd0, {1'b0, 1'b1, 4'b0, t[25], 1'b0});
            wr(3'd1, {4'b0000, 1'b1, t[31], 1'b0, t[24]});
            wr(3'd2, {2'b00, t[28:27], t[26], t[30:29], 1'b0});
            wr(3'd3, t[15:8]);
            wr(3'd4, t[23:16]);
            exp_frame({t[24], t[7:0]}, t[31:29], t[28:27], t[26], f, n);
            p = (t[25] ? 8 : 16) * (int'(t[23:8]) + 1);
            wr(3'd5, t[7:0]);
            rd(3'd0, rv); chk(rv[5] == 1'b0, "R5", "empty cleared by write", rv[5], 0);
            capture(f, n, p, "R1/R2/R3/R4 vector");
            rd(3'd0, rv);
            chk(rv[6] == 1'b1 && rv[5] == 1'b1 && txd === 1'b1, "R6", "done after frame",
                {rv[6], rv[5], txd}, 3'b111);
        end

        // R6 clear by writing 1, empty not writable
        wr(3'd0, 8'h42);
        rd(3'd0, rv); chk(rv == 8'h22, "R6", "write-one clears done, empty kept", rv, 8'h22);

        // R5 back-to-back frames, 8N1, period 8
        wr(3'd2, 8'h06); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd1, 8'h08);
        exp_frame(9'h011, 3'd3, 2'd0, 1'b0, f, n);
        exp_frame(9'h022, 3'd3, 2'd0, 1'b0, f2, n2);
        f2 = f2 << n;
        f2 = f2 | (f & ((32'd1 << n) - 32'd1));
        wr(3'd5, 8'h11);
        fork
            wr(3'd5, 8'h22);
            capture(f2, n + n2, 8, "R5 back-to-back");
        join
        rd(3'd0, rv);
        chk(rv[6] == 1'b1 && txd === 1'b1, "R5", "done after second frame", {rv[6], txd}, 2'b11);
        wr(3'd0, 8'h42);

        // R8 disable during a frame lets it finish
        exp_frame(9'h096, 3'd3, 2'd0, 1'b0, f, n);
        wr(3'd5, 8'h96);
        fork
            begin repeat (30) @(negedge clk); wr(3'd1, 8'h00); end
            capture(f, n, 8, "R8 disable mid-frame");
        join
        rd(3'd0, rv);
        chk(rv[6] == 1'b1 && txd === 1'b1, "R8", "done after disabled frame", {rv[6], txd}, 2'b11);
        wr(3'd5, 8'h77);
        all_high = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) all_high = 0;
        end
        chk(all_high, "R8", "line after disabled write", 0, 1);

        // R9 interrupt requests
        wr(3'd1, 8'h68);
        #1;
        chk(irq_empty === 1'b0 && irq_done === 1'b0, "R9", "requests with gie low",
            {irq_empty, irq_done}, 0);
        @(negedge clk); gie = 1'b1; #1;
        chk(irq_empty === 1'b1 && irq_done === 1'b1, "R9", "requests with gie high",
            {irq_empty, irq_done}, 3);
        pulse_ack(1'b0);
        rd(3'd0, rv);
        chk(irq_empty === 1'b0 && rv[5] == 1'b0, "R9", "empty ack", {irq_empty, rv[5]}, 0);
        pulse_ack(1'b1);
        rd(3'd0, rv);
        chk(irq_done === 1'b0 && rv[6] == 1'b0, "R9", "done ack", {irq_done, rv[6]}, 0);
        wr(3'd5, 8'h5A);
        repeat (10 * 8 + 6) @(negedge clk);
        #1;
        chk(irq_done === 1'b1 && irq_empty === 1'b1, "R9", "requests after frame",
            {irq_empty, irq_done}, 3);

        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule